// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block turns single register accesses from a host into timed bus cycles on an 8-bit asynchronous NAND flash interface. Writing a command opcode produces a cycle with the command-latch line high. Writing an address byte produces a cycle with the address-latch line high. Writing to the data register strobes the write-enable line, and a host read of the data register strobes the read-enable line. Every cycle has three phases: setup, strobe pulse and hold. Each phase takes its length from a timing word, which keeps separate fields for read cycles and write cycles.

Chip enable is controlled only by a configuration bit that can force it low. This lets software keep the device selected across a whole command-and-address sequence. After each cycle the block waits a programmable number of clock pairs and then samples the device's ready/busy pin into a status bit. A control write resets the sequencer: it abandons any cycle in flight and clears the configuration.

Top module: `nand_bus_seq`

## Requirements
- R1: Register select codes are 0 data, 1 address, 2 command, 3 control, 4 config, 5 status, 6 timing. The timing word holds eight 4-bit fields. From bit 0 upward they are: read setup, read hold, read pulse, read ready-delay, write setup, write hold, write pulse, write ready-delay. Reset clears the timing word, config and status. The timing word reads back exactly as written.
- R2: The setup phase lasts v+1 clocks, where v is the setup field for the cycle's direction. During setup both strobes are high, and the latch lines and write data are already valid.
- R3: The strobe pulse lasts v+1 clocks, where v is the pulse field for the cycle's direction. Only one strobe is low at a time: write-enable for command, address and data writes, read-enable for data reads.
- R4: The hold phase lasts v+1 clocks, where v is the hold field for the cycle's direction. The strobe is high again and the latch lines and data are unchanged.
- R5: The command-latch line is high only during command cycles. The address-latch line is high only during address cycles. Neither is high during data cycles.
- R6: A write cycle drives bits 7:0 of the host write data, with output enable high. A read cycle never enables the output driver.
- R7: A read cycle captures the input byte on the last clock of the read-enable pulse. Host reads of the data register then return that byte in bits 7:0.
- R8: Busy rises on the clock that accepts a bus-cycle request and falls on the clock that ends the hold phase. Any request other than a control write is ignored while busy is high.
- R9: Chip enable (active low) is low while config bit 0 is set and high while it is clear, across all cycles.
- R10: Let n be the ready-delay field for the cycle's direction. On the 2n+1-th clock after the clock that ends the hold phase, the ready pin is sampled into status bit 0.
- R11: A control write with bit 0 set is accepted even while busy. It returns the sequencer to idle at once, with both strobes high and output disabled, and clears the config, the timing word and the ready status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access request, one clock |
| host_we | input | 1 | 1 = write, 0 = read |
| host_sel | input | 3 | Register select |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for the selected register (combinational) |
| host_busy | output | 1 | Bus cycle in progress |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data driven to the device |
| nand_dq_oe | output | 1 | Data output enable |
| nand_dq_in | input | 8 | Data from the device |
| nand_rdy | input | 1 | Device ready/busy pin |

## Verification
The bound checker checks the following on every clock:
- the two latch lines are never high together;
- the two strobes are never low together;
- a strobe is low only while busy is high;
- the output driver is off whenever read-enable is low;
- driven data stays stable for the whole of a write cycle.

Only the bench scenarios can show the exact phase lengths, the per-direction field selection, the capture clock for read data, the exact ready-sample clock, and the effects of an abort. The bench therefore sweeps setup, pulse and hold over the values 0, 1, 7 and 15 in both directions. In each case the opposite direction's fields hold different values.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
    localparam int HOST_W = 32;
    localparam int BUS_W  = 8;
    localparam int FLD_W  = 4;
    localparam int SEL_W  = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_DATA = 3'd0,
        SEL_ADDR = 3'd1,
        SEL_CMD  = 3'd2,
        SEL_CTRL = 3'd3,
        SEL_CFG  = 3'd4,
        SEL_STAT = 3'd5,
        SEL_TIME = 3'd6
    } reg_sel_e;

    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_PULSE, PH_HOLD} phase_e;
    typedef enum logic [1:0] {K_CMD, K_ADDR, K_WDATA, K_RDATA} kind_e;

    // lowest field is setup, then hold, pulse, ready-delay
    typedef struct packed {
        logic [FLD_W-1:0] rdy;
        logic [FLD_W-1:0] width;
        logic [FLD_W-1:0] hold;
        logic [FLD_W-1:0] setup;
    } dir_timing_t;

    typedef struct packed {
        dir_timing_t wr;
        dir_timing_t rd;
    } timing_t;

    function automatic dir_timing_t pick_dir(timing_t t, logic is_read);
        return is_read ? t.rd : t.wr;
    endfunction
endpackage

// File: rtl/nbs_regs.sv
module nbs_regs
    import nbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              ctrl_wr,
    input  reg_sel_e          sel,
    input  logic [HOST_W-1:0] wdata,
    output timing_t           timing,
    output logic              force_ce,
    output logic              soft_rst
);
    assign soft_rst = ctrl_wr && wdata[0];

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            timing   <= '0;
            force_ce <= 1'b0;
        end else if (cfg_wr) begin
            case (sel)
                SEL_CFG:  force_ce <= wdata[0];
                SEL_TIME: timing   <= timing_t'(wdata);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/nbs_phase_fsm.sv
module nbs_phase_fsm
    import nbs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             abort,
    input  logic             start,
    input  kind_e            start_kind,
    input  logic [BUS_W-1:0] start_byte,
    input  timing_t          timing,
    input  logic [BUS_W-1:0] dq_in,
    output phase_e           phase,
    output kind_e            kind,
    output logic [BUS_W-1:0] wbyte,
    output logic [BUS_W-1:0] rbyte,
    output logic             finish,
    output logic [FLD_W-1:0] finish_delay
);
    logic [FLD_W-1:0] cnt;
    dir_timing_t      t_now, t_start;

    assign t_now        = pick_dir(timing, kind == K_RDATA);
    assign t_start      = pick_dir(timing, start_kind == K_RDATA);
    assign finish       = (phase == PH_HOLD) && (cnt == '0);
    assign finish_delay = t_now.rdy;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            phase <= PH_IDLE;
            kind  <= K_CMD;
            cnt   <= '0;
            wbyte <= '0;
            rbyte <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    phase <= PH_SETUP;
                    kind  <= start_kind;
                    wbyte <= start_byte;
                    cnt   <= t_start.setup;
                end
                PH_SETUP: if (cnt == '0) begin
                    phase <= PH_PULSE;
                    cnt   <= t_now.width;
                end else cnt <= cnt - 1'b1;
                PH_PULSE: if (cnt == '0) begin
                    phase <= PH_HOLD;
                    cnt   <= t_now.hold;
                    if (kind == K_RDATA) rbyte <= dq_in;
                end else cnt <= cnt - 1'b1;
                PH_HOLD: if (cnt == '0) phase <= PH_IDLE;
                         else cnt <= cnt - 1'b1;
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nbs_ready_sampler.sv
module nbs_ready_sampler
    import nbs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             trigger,
    input  logic [FLD_W-1:0] delay,
    input  logic             pin,
    output logic             ready
);
    localparam int CW = FLD_W + 1;
    logic [CW-1:0] wait_cnt;
    logic          armed;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            armed    <= 1'b0;
            wait_cnt <= '0;
            ready    <= 1'b0;
        end else if (trigger) begin
            armed    <= 1'b1;
            wait_cnt <= {delay, 1'b0};
        end else if (armed) begin
            if (wait_cnt == '0) begin
                ready <= pin;
                armed <= 1'b0;
            end else begin
                wait_cnt <= wait_cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq
    import nbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [SEL_W-1:0]  host_sel,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [HOST_W-1:0] host_rdata,
    output logic              host_busy,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [BUS_W-1:0]  nand_dq_out,
    output logic              nand_dq_oe,
    input  logic [BUS_W-1:0]  nand_dq_in,
    input  logic              nand_rdy
);
    reg_sel_e         sel;
    phase_e           phase;
    kind_e            kind, start_kind;
    timing_t          timing;
    logic             force_ce, soft_rst, accept, start_bus, cfg_wr, ctrl_wr;
    logic             finish, rdy_stat, active;
    logic [BUS_W-1:0] wbyte, rbyte;
    logic [FLD_W-1:0] finish_delay;

    assign sel       = reg_sel_e'(host_sel);
    assign active    = (phase != PH_IDLE);
    assign host_busy = active;
    assign accept    = host_req && !active;
    assign cfg_wr    = accept && host_we;
    assign ctrl_wr   = host_req && host_we && (sel == SEL_CTRL);

    always_comb begin
        start_bus  = 1'b0;
        start_kind = K_CMD;
        if (accept) begin
            case (sel)
                SEL_CMD:  begin start_bus = host_we; start_kind = K_CMD;  end
                SEL_ADDR: begin start_bus = host_we; start_kind = K_ADDR; end
                SEL_DATA: begin
                    start_bus  = 1'b1;
                    start_kind = host_we ? K_WDATA : K_RDATA;
                end
                default: ;
            endcase
        end
    end

    nbs_regs u_regs (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .ctrl_wr(ctrl_wr), .sel(sel),
        .wdata(host_wdata), .timing(timing), .force_ce(force_ce), .soft_rst(soft_rst)
    );

    nbs_phase_fsm u_fsm (
        .clk(clk), .rst(rst), .abort(soft_rst), .start(start_bus),
        .start_kind(start_kind), .start_byte(host_wdata[BUS_W-1:0]),
        .timing(timing), .dq_in(nand_dq_in), .phase(phase), .kind(kind),
        .wbyte(wbyte), .rbyte(rbyte), .finish(finish), .finish_delay(finish_delay)
    );

    nbs_ready_sampler u_rdy (
        .clk(clk), .rst(rst), .clear(soft_rst), .trigger(finish),
        .delay(finish_delay), .pin(nand_rdy), .ready(rdy_stat)
    );

    assign nand_ce_n   = !force_ce;
    assign nand_cle    = active && (kind == K_CMD);
    assign nand_ale    = active && (kind == K_ADDR);
    assign nand_we_n   = !((phase == PH_PULSE) && (kind != K_RDATA));
    assign nand_re_n   = !((phase == PH_PULSE) && (kind == K_RDATA));
    assign nand_dq_oe  = active && (kind != K_RDATA);
    assign nand_dq_out = nand_dq_oe ? wbyte : '0;

    always_comb begin
        host_rdata = '0;
        case (sel)
            SEL_DATA: host_rdata[BUS_W-1:0] = rbyte;
            SEL_CFG:  host_rdata[0]         = force_ce;
            SEL_STAT: host_rdata[0]         = rdy_stat;
            SEL_TIME: host_rdata            = timing;
            default: ;
        endcase
    end
endmodule

// File: rtl/nand_bus_seq_checker.sv
module nand_bus_seq_checker
    import nbs_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             cle,
    input logic             ale,
    input logic             we_n,
    input logic             re_n,
    input logic             dq_oe,
    input logic [BUS_W-1:0] dq_out
);
    assert_latch_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(cle && ale));

    assert_one_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !re_n));

    assert_strobe_in_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (!we_n || !re_n) |-> busy);

    assert_no_drive_on_read_R6: assert property (@(posedge clk) disable iff (rst)
        !re_n |-> !dq_oe);

    assert_dq_steady_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && dq_oe && $past(dq_oe)) |-> $stable(dq_out));
endmodule

bind nand_bus_seq nand_bus_seq_checker u_chk (
    .clk(clk), .rst(rst), .busy(host_busy), .cle(nand_cle), .ale(nand_ale),
    .we_n(nand_we_n), .re_n(nand_re_n), .dq_oe(nand_dq_oe), .dq_out(nand_dq_out)
);

// File: tb/nand_bus_seq_test.sv
module nand_bus_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0, we = 1'b0;
    logic [2:0]  sel = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        busy, ce_n, cle, ale, we_n, re_n, dq_oe, rdy = 1'b0;
    logic [7:0]  dq_out, dq_in = 8'hEE, pat = 8'h20;
    bit          exp_ce = 1'b0;
    int          n_checks = 0, n_fail = 0;

    always #4 clk = ~clk;

    nand_bus_seq uut (
        .clk(clk), .rst(rst), .host_req(req), .host_we(we), .host_sel(sel),
        .host_wdata(wdata), .host_rdata(rdata), .host_busy(busy),
        .nand_ce_n(ce_n), .nand_cle(cle), .nand_ale(ale), .nand_we_n(we_n),
        .nand_re_n(re_n), .nand_dq_out(dq_out), .nand_dq_oe(dq_oe),
        .nand_dq_in(dq_in), .nand_rdy(rdy)
    );

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic wait_idle();
        int g = 0;
        while (busy && g < 500) begin @(negedge clk); g++; end
    endtask

    task automatic host_write(input logic [2:0] s, input logic [31:0] d);
        wait_idle();
        req = 1'b1; we = 1'b1; sel = s; wdata = d;
        @(negedge clk);
        req = 1'b0;
    endtask

    // issues one bus cycle and measures its phases at negedges
    task automatic bus_cycle(input logic [2:0] s, input logic w, input logic [31:0] d,
                             input int ts, input int tw, input int th);
        int  n_set = 0, n_pul = 0, n_hold = 0, g = 0;
        bit  lat_bad = 0, dq_bad = 0, ce_bad = 0, strb_bad = 0;
        bit  is_rd = !w;
        bit  e_cle = w && (s == 3'd2);
        bit  e_ale = w && (s == 3'd1);
        logic [7:0] last = 8'h00;
        wait_idle();
        req = 1'b1; we = w; sel = s; wdata = d;
        @(negedge clk);
        req = 1'b0;
        while (busy && g < 200) begin
            g++;
            if (is_rd ? !we_n : !re_n) strb_bad = 1;
            if (is_rd ? !re_n : !we_n) begin
                n_pul++;
                if (n_hold != 0) strb_bad = 1;
                if (is_rd) begin pat = pat + 8'd3; dq_in = pat; last = pat; end
            end else if (n_pul == 0) n_set++;
            else n_hold++;
            if (cle !== e_cle || ale !== e_ale) lat_bad = 1;
            if (ce_n !== !exp_ce) ce_bad = 1;
            if (dq_oe !== !is_rd) dq_bad = 1;
            if (!is_rd && dq_out !== d[7:0]) dq_bad = 1;
            @(negedge clk);
        end
        if (is_rd) dq_in = 8'hEE;
        check(n_set == ts + 1, "R2", "setup clocks", n_set, ts + 1);
        check(n_pul == tw + 1 && !strb_bad, "R3", "pulse clocks", n_pul, tw + 1);
        check(n_hold == th + 1, "R4", "hold clocks", n_hold, th + 1);
        check(!lat_bad, "R5", "latch lines", lat_bad, 0);
        check(!dq_bad, "R6", "data drive", dq_bad, 0);
        check(!ce_bad, "R9", "chip enable", ce_bad, 0);
        if (is_rd) begin
            sel = 3'd0;
            #1 check(rdata == {24'h0, last}, "R7", "captured byte", rdata, last);
        end
    endtask

    task automatic rdy_test(input bit rd, input int n);
        rdy = 1'b0;
        host_write(3'd6, rd ? (n << 12) : (n << 28));
        bus_cycle(rd ? 3'd0 : 3'd2, !rd, 32'h5A, 0, 0, 0);
        repeat (40) @(negedge clk);
        sel = 3'd5;
        #1 check(rdata[0] == 1'b0, "R10", "ready low baseline", rdata[0], 0);
        bus_cycle(rd ? 3'd0 : 3'd2, !rd, 32'hA5, 0, 0, 0);
        rdy = 1'b1; sel = 3'd5;
        for (int k = 1; k <= 2 * n + 2; k++) begin
            if (k == 2 * n + 1)
                check(rdata[0] == 1'b0, "R10", "ready before sample", rdata[0], 0);
            if (k == 2 * n + 2)
                check(rdata[0] == 1'b1, "R10", "ready after sample", rdata[0], 1);
            @(negedge clk);
        end
    endtask

    initial begin
        #(8 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int vals [4] = '{0, 1, 7, 15};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        sel = 3'd6; #1 check(rdata == 0, "R1", "timing reset", rdata, 0);
        sel = 3'd4; #1 check(rdata == 0, "R1", "config reset", rdata, 0);
        sel = 3'd5; #1 check(rdata == 0, "R1", "status reset", rdata, 0);
        check(!busy && we_n && re_n && ce_n && !dq_oe, "R1", "idle pins",
              {busy, we_n, re_n, ce_n, dq_oe}, 5'b01110);
        host_write(3'd6, 32'h9ABC_DEF1);
        sel = 3'd6; #1 check(rdata == 32'h9ABC_DEF1, "R1", "timing readback", rdata, 32'h9ABC_DEF1);

        // write sweep, read fields set to other values
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                for (int c = 0; c < 4; c++) begin
                    int s = vals[a], w = vals[b], h = vals[c];
                    logic [2:0] rs = (a + b + c) % 3 == 0 ? 3'd2 : ((a + b + c) % 3 == 1 ? 3'd1 : 3'd0);
                    host_write(3'd6, (w << 24) | (h << 20) | (s << 16) |
                                     ((15 - w) << 8) | ((15 - h) << 4) | (15 - s));
                    bus_cycle(rs, 1'b1, 32'hABCD_1200 | (a * 16 + b * 4 + c), s, w, h);
                end
        // read sweep, write fields set to other values
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                for (int c = 0; c < 4; c++) begin
                    int s = vals[a], w = vals[b], h = vals[c];
                    host_write(3'd6, ((15 - w) << 24) | ((15 - h) << 20) | ((15 - s) << 16) |
                                     (w << 8) | (h << 4) | s);
                    bus_cycle(3'd0, 1'b0, 32'h0, s, w, h);
                end

        // R9 forced chip enable across command and address
        host_write(3'd6, 32'h0);
        host_write(3'd4, 32'h1);
        exp_ce = 1'b1;
        check(ce_n == 1'b0, "R9", "ce forced low", ce_n, 0);
        bus_cycle(3'd2, 1'b1, 32'h70, 0, 0, 0);
        bus_cycle(3'd1, 1'b1, 32'h12, 0, 0, 0);
        host_write(3'd4, 32'h0);
        exp_ce = 1'b0;
        check(ce_n == 1'b1, "R9", "ce released", ce_n, 1);

        // R8 request while busy is ignored
        begin
            int nb = 0, extra = 0;
            host_write(3'd6, 32'h0333_0000);
            req = 1'b1; we = 1'b1; sel = 3'd2; wdata = 32'h55;
            @(negedge clk); req = 1'b0; nb = 1;
            @(negedge clk); nb++;
            req = 1'b1; sel = 3'd1; wdata = 32'h99;
            @(negedge clk); req = 1'b0; nb++;
            while (busy && nb < 100) begin @(negedge clk); nb++; end
            check(nb == 13, "R8", "busy clocks", nb, 13);
            repeat (5) begin
                if (busy || ale) extra++;
                @(negedge clk);
            end
            check(extra == 0, "R8", "ignored request", extra, 0);
        end

        // R10 ready sampling delay
        foreach (vals[i]) rdy_test(1'b1, vals[i] == 7 ? 5 : vals[i]);
        rdy_test(1'b0, 2);
        rdy_test(1'b0, 15);

        // R11 abort mid-cycle
        host_write(3'd4, 32'h1);
        host_write(3'd6, 32'hFFFF_FFFF);
        req = 1'b1; we = 1'b0; sel = 3'd0;
        @(negedge clk); req = 1'b0;
        repeat (18) @(negedge clk);
        check(busy && !re_n, "R11", "in pulse before abort", {busy, re_n}, 2'b10);
        req = 1'b1; we = 1'b1; sel = 3'd3; wdata = 32'h1;
        @(negedge clk); req = 1'b0;
        check(!busy && re_n && we_n && !dq_oe && ce_n, "R11", "abort pins",
              {busy, re_n, we_n, dq_oe, ce_n}, 5'b01101);
        sel = 3'd6; #1 check(rdata == 0, "R11", "timing cleared", rdata, 0);
        sel = 3'd4; #1 check(rdata == 0, "R11", "config cleared", rdata, 0);
        sel = 3'd5; #1 check(rdata == 0, "R11", "status cleared", rdata, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule